// File: doc/BRIEF.md
# Three-Class Vectored Interrupt Controller

This block collects a bank of interrupt request lines and sorts every line into one of three classes. A line marked fast drives a dedicated fast-interrupt output. A line bound to one of the vector slots is a vectored request. Every other enabled line is a non-vectored request. Both kinds of normal request drive a single normal-interrupt output. Fast requests always take precedence over normal ones. Among normal requests, a lower slot number wins, and non-vectored requests rank last.

The processor services a normal interrupt by reading one register. That read returns the handler address of the winning slot, or a programmable default address when only non-vectored work is pending. The same read records the winner's level as in service, so requests of that level or lower are held back until software writes the vector register to signal end of service. A request of higher priority can still interrupt a handler, which gives priority-ordered nesting.

Software reaches the controller through a plain register port. A read is registered, so its data appears one cycle after the read strobe.

Top module: `vic_top`

## Requirements
- R1: After reset every register reads zero, `fiq_o` and `irq_o` are low, and a vector read returns zero.
- R2: Offset 0x00 returns the raw lines (`irq_i` OR the soft-set register at 0x14). Offset 0x04 returns raw & enable & ~fast. Offset 0x08 returns raw & enable & fast.
- R3: `fiq_o` is high one cycle after any enabled line selected as fast (select register 0x10) is raised. Fast lines never raise `irq_o` and are never returned by a vector read.
- R4: `irq_o` rises one cycle after an enabled, non-fast line becomes pending, provided no level of equal or higher priority is in service.
- R5: Slot k has its handler address at 0x40+4k and its control at 0x80+4k, with bit 5 as enable and bits 4:0 as the source number. A vector read (0x18) returns the address of the lowest-numbered enabled slot whose source is pending.
- R6: When the only pending normal requests are not claimed by any enabled slot, a vector read returns the default address register (0x1C).
- R7: A vector read that sees `irq_o` asserted marks the winner's level in service. After that, `irq_o` stays low unless a strictly higher-priority request is pending.
- R8: Any write to 0x18 ends service of the highest-priority level in service, and `irq_o` re-asserts for requests that are still pending.
- R9: A line whose bit in the enable register (0x0C) is zero affects neither output nor the status at 0x04 and 0x08.
- R10: The enable, fast-select, soft-set, default and slot registers read back as written. `rdata_o` is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Interrupt request lines, active high |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
A wrong in-service record shows up at the ports within two cycles. `irq_o` stays low while a request is pending, or it fails to drop after a vector read. A wrong slot ranking returns a different handler address on the very next vector read. The sequence therefore nests a higher slot over a lower one, ends service one level at a time, and checks `irq_o` after each step. It also reads the vector address whenever the set of pending lines changes.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [7:0] OFS_RAW  = 8'h00;
  localparam logic [7:0] OFS_NRM  = 8'h04;
  localparam logic [7:0] OFS_FST  = 8'h08;
  localparam logic [7:0] OFS_EN   = 8'h0C;
  localparam logic [7:0] OFS_FSEL = 8'h10;
  localparam logic [7:0] OFS_SOFT = 8'h14;
  localparam logic [7:0] OFS_VEC  = 8'h18;
  localparam logic [7:0] OFS_DFLT = 8'h1C;
  localparam logic [1:0] RGN_ADDR = 2'b01;  // 0x40..0x7F slot handler addresses
  localparam logic [1:0] RGN_CTL  = 2'b10;  // 0x80..0xBF slot controls
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned AW     = 8,
  localparam int unsigned SW    = $clog2(N_SRC),
  localparam int unsigned IW    = $clog2(N_SLOT)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [AW-1:0]                  addr_i,
  input  logic                           wr_i,
  input  logic                           rd_i,
  input  logic [31:0]                    wdata_i,
  input  logic [N_SRC-1:0]               raw_i,
  input  logic [N_SRC-1:0]               nrm_i,
  input  logic [N_SRC-1:0]               fst_i,
  input  logic [31:0]                    vec_i,
  output logic [31:0]                    rdata_o,
  output logic [N_SRC-1:0]               en_o,
  output logic [N_SRC-1:0]               fsel_o,
  output logic [N_SRC-1:0]               soft_o,
  output logic [31:0]                    dflt_o,
  output logic [N_SLOT-1:0]              slot_en_o,
  output logic [N_SLOT-1:0][SW-1:0]      slot_src_o,
  output logic [N_SLOT-1:0][31:0]        slot_addr_o
);
  logic [IW-1:0] sidx;
  logic          in_addr_rgn, in_ctl_rgn;
  logic [31:0]   rmux;

  assign sidx        = addr_i[IW+1:2];
  assign in_addr_rgn = (addr_i[AW-1:6] == (AW-6)'(RGN_ADDR)) && (32'(sidx) < N_SLOT);
  assign in_ctl_rgn  = (addr_i[AW-1:6] == (AW-6)'(RGN_CTL))  && (32'(sidx) < N_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      fsel_o <= '0;
      soft_o <= '0;
      dflt_o <= '0;
    end else if (wr_i) begin
      if (addr_i == AW'(OFS_EN))   en_o   <= wdata_i[N_SRC-1:0];
      if (addr_i == AW'(OFS_FSEL)) fsel_o <= wdata_i[N_SRC-1:0];
      if (addr_i == AW'(OFS_SOFT)) soft_o <= wdata_i[N_SRC-1:0];
      if (addr_i == AW'(OFS_DFLT)) dflt_o <= wdata_i;
    end
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_en_o[k]   <= 1'b0;
        slot_src_o[k]  <= '0;
        slot_addr_o[k] <= '0;
      end else if (wr_i && sidx == IW'(k)) begin
        if (in_addr_rgn) slot_addr_o[k] <= wdata_i;
        if (in_ctl_rgn) begin
          slot_en_o[k]  <= wdata_i[SW];
          slot_src_o[k] <= wdata_i[SW-1:0];
        end
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (in_addr_rgn)     rmux = slot_addr_o[sidx];
    else if (in_ctl_rgn) rmux = 32'(slot_src_o[sidx]) | (32'(slot_en_o[sidx]) << SW);
    else begin
      case (addr_i)
        AW'(OFS_RAW):  rmux = 32'(raw_i);
        AW'(OFS_NRM):  rmux = 32'(nrm_i);
        AW'(OFS_FST):  rmux = 32'(fst_i);
        AW'(OFS_EN):   rmux = 32'(en_o);
        AW'(OFS_FSEL): rmux = 32'(fsel_o);
        AW'(OFS_SOFT): rmux = 32'(soft_o);
        AW'(OFS_VEC):  rmux = vec_i;
        AW'(OFS_DFLT): rmux = dflt_o;
        default:       rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_i ? rmux : '0;
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  localparam int unsigned SW    = $clog2(N_SRC),
  localparam int unsigned LW    = $clog2(N_SLOT + 2)
) (
  input  logic [N_SRC-1:0]          nrm_i,
  input  logic [N_SLOT-1:0]         slot_en_i,
  input  logic [N_SLOT-1:0][SW-1:0] slot_src_i,
  output logic                      win_vld_o,
  output logic [LW-1:0]             win_lvl_o
);
  logic [N_SLOT-1:0] hit;
  logic [N_SRC-1:0]  claim;
  logic              nonvec;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_hit
    assign hit[k] = slot_en_i[k] & nrm_i[slot_src_i[k]];
  end

  always_comb begin
    claim = '0;
    for (int k = 0; k < N_SLOT; k++)
      if (slot_en_i[k]) claim[slot_src_i[k]] = 1'b1;
  end

  assign nonvec = |(nrm_i & ~claim);

  // lowest slot index wins; non-vectored sits at level N_SLOT
  always_comb begin
    win_vld_o = nonvec;
    win_lvl_o = LW'(N_SLOT);
    for (int k = N_SLOT - 1; k >= 0; k--) begin
      if (hit[k]) begin
        win_vld_o = 1'b1;
        win_lvl_o = LW'(k);
      end
    end
  end
endmodule

// File: rtl/vic_service.sv
module vic_service #(
  parameter int unsigned N_SLOT = 16,
  localparam int unsigned NL    = N_SLOT + 1,
  localparam int unsigned LW    = $clog2(N_SLOT + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  input  logic          eos_i,
  input  logic [LW-1:0] lvl_i,
  output logic [NL-1:0] serv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    serv_o <= '0;
    else if (eos_i) serv_o <= serv_o & (serv_o - NL'(1));  // drop highest-priority level
    else if (ack_i) serv_o <= serv_o | (NL'(1) << lvl_i);
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned AW     = 8,
  localparam int unsigned SW    = $clog2(N_SRC),
  localparam int unsigned IW    = $clog2(N_SLOT),
  localparam int unsigned LW    = $clog2(N_SLOT + 2),
  localparam int unsigned NL    = N_SLOT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]          en_q, fast_q, soft_q, raw_w, masked_w, nrm_w, fst_w;
  logic [31:0]               dflt_q, vec_w;
  logic [N_SLOT-1:0]         slot_en_q;
  logic [N_SLOT-1:0][SW-1:0] slot_src_q;
  logic [N_SLOT-1:0][31:0]   slot_addr_q;
  logic                      win_vld;
  logic [LW-1:0]             win_lvl, serv_lvl;
  logic [NL-1:0]             serv_q;
  logic                      irq_d, ack_w, eos_w;

  assign raw_w    = irq_i | soft_q;
  assign masked_w = raw_w & en_q;
  assign nrm_w    = masked_w & ~fast_q;
  assign fst_w    = masked_w & fast_q;

  vic_regs #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .raw_i(raw_w), .nrm_i(nrm_w), .fst_i(fst_w), .vec_i(vec_w),
    .rdata_o, .en_o(en_q), .fsel_o(fast_q), .soft_o(soft_q), .dflt_o(dflt_q),
    .slot_en_o(slot_en_q), .slot_src_o(slot_src_q), .slot_addr_o(slot_addr_q)
  );

  vic_prio #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_prio (
    .nrm_i(nrm_w), .slot_en_i(slot_en_q), .slot_src_i(slot_src_q),
    .win_vld_o(win_vld), .win_lvl_o(win_lvl)
  );

  always_comb begin
    serv_lvl = LW'(NL);
    for (int k = NL - 1; k >= 0; k--)
      if (serv_q[k]) serv_lvl = LW'(k);
  end

  assign irq_d = win_vld && (win_lvl < serv_lvl);
  assign vec_w = (irq_d && win_lvl < LW'(N_SLOT)) ? slot_addr_q[win_lvl[IW-1:0]] : dflt_q;
  assign ack_w = rd_i && (addr_i == AW'(OFS_VEC)) && irq_d;
  assign eos_w = wr_i && (addr_i == AW'(OFS_VEC));

  vic_service #(.N_SLOT(N_SLOT)) u_serv (
    .clk_i, .rst_ni, .ack_i(ack_w), .eos_i(eos_w), .lvl_i(win_lvl), .serv_o(serv_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      fiq_o <= |fst_w;
      irq_o <= irq_d;
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [31:0]       rdata_o,
  input logic              fiq_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  fst_w,
  input logic [N_SRC-1:0]  nrm_w,
  input logic [N_SLOT:0]   serv_q,
  input logic              ack_w,
  input logic              eos_w
);
  AST_FIQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fst_w) |=> fiq_o);  // R3
  AST_FIQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fst_w) |=> !fiq_o);  // R9
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm_w == '0) |=> !irq_o);  // R4
  AST_ACK_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && !eos_w) |=> ($countones(serv_q) == $countones($past(serv_q)) + 1));  // R7
  AST_EOS_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_w && serv_q != '0) |=> ($countones(serv_q) + 1 == $countones($past(serv_q))));  // R8
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));  // R10
endmodule

bind vic_top vic_checker #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_chk (
  .clk_i, .rst_ni, .rd_i, .rdata_o, .fiq_o, .irq_o,
  .fst_w, .nrm_w, .serv_q, .ack_w, .eos_w
);

// File: tb/tb_vic_top.sv
module tb_vic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq_o, irq_o;
  logic        rd_pend = 1'b0;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  vic_top dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data in the cycle after each read strobe
  always @(posedge clk) rd_pend <= rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) check("scoreboard underrun", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk);
    irq = v;
    idle(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(2);
    check("R1 fiq_o after reset", 32'(fiq_o), 32'h0);
    check("R1 irq_o after reset", 32'(irq_o), 32'h0);
    reg_rd(8'h0C, 32'h0, "R1 enable reset");
    reg_rd(8'h18, 32'h0, "R1 vector reset");

    // fast class; bit 7 left disabled
    reg_wr(8'h0C, 32'hFFFF_FF7F);
    reg_wr(8'h10, 32'h0000_0008);
    set_irq(32'h0000_0008);
    check("R3 fiq_o on fast line", 32'(fiq_o), 32'h1);
    check("R3 irq_o stays low", 32'(irq_o), 32'h0);
    reg_rd(8'h08, 32'h0000_0008, "R2 fast status");
    reg_rd(8'h04, 32'h0, "R2 normal status");
    reg_rd(8'h18, 32'h0, "R3 fast not vectored");

    // disabled line
    set_irq(32'h0000_0080);
    check("R9 fiq_o disabled", 32'(fiq_o), 32'h0);
    check("R9 irq_o disabled", 32'(irq_o), 32'h0);
    reg_rd(8'h00, 32'h0000_0080, "R2 raw shows disabled line");
    reg_rd(8'h04, 32'h0, "R9 normal status disabled");

    // slots: slot0 <- src10, slot2 <- src4
    reg_wr(8'h1C, 32'hDEAD_0000);
    reg_wr(8'h40, 32'h0000_1000);
    reg_wr(8'h80, 32'h0000_002A);
    reg_wr(8'h48, 32'h0000_1200);
    reg_wr(8'h88, 32'h0000_0024);

    set_irq(32'h0010_0000);
    check("R4 irq_o non-vectored", 32'(irq_o), 32'h1);
    reg_rd(8'h04, 32'h0010_0000, "R2 normal status");
    reg_rd(8'h18, 32'hDEAD_0000, "R6 default address");
    idle(2);
    check("R7 irq_o held in service", 32'(irq_o), 32'h0);
    reg_wr(8'h18, 32'h0);
    idle(2);
    check("R8 irq_o after end of service", 32'(irq_o), 32'h1);

    set_irq(32'h0010_0010);
    reg_rd(8'h18, 32'h0000_1200, "R5 slot2 address");
    idle(2);
    check("R7 lower level blocked", 32'(irq_o), 32'h0);
    set_irq(32'h0010_0410);
    check("R7 higher slot preempts", 32'(irq_o), 32'h1);
    reg_rd(8'h18, 32'h0000_1000, "R5 slot0 wins");
    idle(2);
    check("R7 irq_o after nested ack", 32'(irq_o), 32'h0);
    set_irq(32'h0010_0010);
    reg_wr(8'h18, 32'h0);
    idle(2);
    check("R8 slot2 still in service", 32'(irq_o), 32'h0);
    reg_wr(8'h18, 32'h0);
    idle(2);
    check("R8 irq_o after last end", 32'(irq_o), 32'h1);
    reg_rd(8'h18, 32'h0000_1200, "R5 slot2 again");
    reg_wr(8'h18, 32'h0);

    // soft set
    set_irq(32'h0);
    reg_wr(8'h14, 32'h0000_0400);
    idle(2);
    reg_rd(8'h00, 32'h0000_0400, "R2 raw includes soft");
    reg_rd(8'h18, 32'h0000_1000, "R5 soft line vectored");
    reg_wr(8'h18, 32'h0);

    // fast line bound to a slot is not vectored
    reg_wr(8'h10, 32'h0000_0408);
    idle(2);
    check("R3 fiq_o from soft fast", 32'(fiq_o), 32'h1);
    check("R3 irq_o low for fast slot", 32'(irq_o), 32'h0);
    reg_rd(8'h18, 32'hDEAD_0000, "R3 fast slot not returned");

    reg_rd(8'h80, 32'h0000_002A, "R10 slot0 control");
    reg_rd(8'h48, 32'h0000_1200, "R10 slot2 address");
    reg_rd(8'h1C, 32'hDEAD_0000, "R10 default");
    reg_rd(8'h10, 32'h0000_0408, "R10 fast select");
    reg_rd(8'h14, 32'h0000_0400, "R10 soft set");
    idle(3);
    check("R10 rdata idle", rdata, 32'h0);
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule